// File: doc/BRIEF.md
# Bridge Outbound Window Decoder

This block sits on the CPU side of a bridge from the host bus to an expansion bus. It classifies each 32-bit CPU address and says whether the bridge should claim it and send it downstream. The top 256 MiB of the address space, from 0xF0000000 to 0xFFFFFFFF, is split into 32 chunks of 8 MiB each. Each chunk can be switched on separately through a bitmap register. A two-bit mode field in a control register switches all forwarding on or off together. The lowest chunk, which holds firmware, and the highest chunk, which holds the bridge's own registers, are never forwarded, whatever the bitmap holds.

The block also holds the bridge's configuration state:
- a two-bit fast-back-to-back enable register;
- a configuration-address register, whose word-aligned copy is driven to the configuration logic downstream;
- a bank of thirteen setup registers, each of which keeps only its implemented low bits on write and returns a few reserved bits as zero on read.

A small combinational check tells the access path which byte offsets and sizes are legal on the I/O data window.

Registers are written through a simple write strobe with an address and data. Reads are combinational from the register address.

Top module: `bridge_window_decoder`

## Requirements
- R1: After synchronous reset, every register reads as zero, `cfg_bus_addr` is zero and `fwd_hit` is 0.
- R2: Forwarding is possible only while control register bits 8:7 (register offset 0x000) equal binary 01. With any other value of that field, `fwd_hit` is 0 for every address.
- R3: When forwarding is enabled, an address in 0xF0000000–0xFFFFFFFF with chunk index i = addr[27:23], where 1 ≤ i ≤ 30, gives `fwd_hit`=1 exactly when bit i of the enable register (offset 0x004) is 1.
- R4: Chunk 0 and chunk 31 are never forwarded, even when enable bits 0 and 31 are set. Those two bits are still stored and read back.
- R5: An address with addr[31:28] ≠ 0xF never gives `fwd_hit`=1.
- R6: A write to the enable or control register does not change the decode during the cycle of the write. The new value governs the decode from the clock edge that takes the write.
- R7: A write to the fast-back-to-back register (offset 0x008) keeps only data bits 1:0. Its upper bits read as zero.
- R8: The setup bank occupies word offsets 0x800 to 0x830. In offset order, its registers keep the low 1, 7, 7, 8, 7, 9, 32, 8, 30, 24, 22, 32 and 9 bits of a write, and store the other bits as zero.
- R9: Certain bank bits always read as zero: bit 0 at 0x804; bits 2:0 at 0x81C; bits 3, 7:5, 15 and 24 at 0x820.
- R10: The configuration-address register (offset 0x00C) reads back all 32 bits as written. `cfg_bus_addr` carries the same value with bits 1:0 cleared.
- R11: `io_ok` is 1 only for these pairs of byte offset `io_offs` and size `io_size` (the size is coded in bytes: 1, 2 or 4):
  - offset 0 with size 1, 2 or 4;
  - offset 2 with size 1 or 2;
  - offset 1 or 3 with size 1.

  Every other combination gives 0.
- R12: `fwd_chunk` equals addr[27:23] while `fwd_hit` is 1, and is 0 otherwise. Unmapped register offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset, used for both writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data at `reg_addr` |
| cpu_addr | input | 32 | CPU address to classify |
| fwd_hit | output | 1 | Address is forwarded downstream |
| fwd_chunk | output | 5 | Index of the forwarded 8 MiB chunk |
| cfg_bus_addr | output | 32 | Word-aligned configuration address sent downstream |
| io_offs | input | 2 | Byte offset of an I/O data window access |
| io_size | input | 3 | Size of that access in bytes |
| io_ok | output | 1 | Access offset and size are legal |

## Verification
Two functions can meet in one cycle: a write to the enable or control register, and the classification of an address that this write affects. The bench holds an address in an enabled chunk while it drives the write during the low phase of the clock. It checks that `fwd_hit` still shows the old setting before the rising edge and the new setting just after it, in both directions and for both registers. The rest of the bench sweeps the following against arithmetic expectations:
- every chunk under each mode value and under several enable bitmaps;
- every bank register under two data patterns;
- every pair of I/O offset and size.

// File: rtl/bwd_pkg.sv
// Package: shared offsets, mode encoding and bank masks for the window decoder.
// Assumes a 12-bit register offset space and 32-bit register data.
package bwd_pkg;

    localparam int          BANK_REGS   = 13;
    localparam logic [11:0] OFF_CTRL    = 12'h000;
    localparam logic [11:0] OFF_ENABLE  = 12'h004;
    localparam logic [11:0] OFF_FBB     = 12'h008;
    localparam logic [11:0] OFF_CFGADDR = 12'h00C;
    localparam logic [11:0] OFF_BANK    = 12'h800;
    localparam int          MODE_LSB    = 7;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_FWD  = 2'b01,
        MODE_RSV2 = 2'b10,
        MODE_RSV3 = 2'b11
    } fwd_mode_e;

    // Number of implemented low bits of each bank register.
    function automatic int bank_width(input int idx);
        case (idx)
            0:       return 1;
            1, 2, 4: return 7;
            3, 7:    return 8;
            5, 12:   return 9;
            6, 11:   return 32;
            8:       return 30;
            9:       return 24;
            10:      return 22;
            default: return 0;
        endcase
    endfunction

    // Write-keep mask of each bank register.
    function automatic logic [31:0] bank_keep(input int idx);
        int w;
        w = bank_width(idx);
        if (w >= 32) return 32'hFFFF_FFFF;
        return (32'd1 << w) - 32'd1;
    endfunction

    // Bits that read as zero whatever is stored.
    function automatic logic [31:0] bank_zero(input int idx);
        case (idx)
            1:       return 32'h0000_0001;
            7:       return 32'h0000_0007;
            8:       return 32'h0100_80E8;
            default: return 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/bwd_ctrl_regs.sv
// Control, chunk-enable, fast-back-to-back and configuration-address registers.
// Assumes writes are single-cycle strobes; all registers clear on synchronous reset.
module bwd_ctrl_regs
    import bwd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] enable_q,
    output logic [1:0]        fbb_q,
    output logic [DATA_W-1:0] cfg_q
);

    logic hit_ctrl, hit_enable, hit_fbb, hit_cfg;

    // Decode which register a write targets.
    always_comb begin
        hit_ctrl   = wr_en && (wr_addr == REG_AW'(OFF_CTRL));
        hit_enable = wr_en && (wr_addr == REG_AW'(OFF_ENABLE));
        hit_fbb    = wr_en && (wr_addr == REG_AW'(OFF_FBB));
        hit_cfg    = wr_en && (wr_addr == REG_AW'(OFF_CFGADDR));
    end

    // Control and enable registers, stored whole.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            enable_q <= '0;
        end else begin
            if (hit_ctrl)   ctrl_q   <= wdata;
            if (hit_enable) enable_q <= wdata;
        end
    end

    // Fast-back-to-back register keeps the two low data bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       fbb_q <= '0;
        else if (hit_fbb) fbb_q <= wdata[1:0];
    end

    // Configuration-address register keeps the full written value.
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_q <= '0;
        else if (hit_cfg) cfg_q <= wdata;
    end

    AST_CFG_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_AW'(OFF_CFGADDR)) |=> (cfg_q == $past(wdata))); // R10

endmodule

// File: rtl/bwd_cfg_bank.sv
// Bank of setup registers with per-register write-keep and read-zero masks.
// Assumes word-aligned offsets starting at OFF_BANK; one register per word.
module bwd_cfg_bank
    import bwd_pkg::*;
#(
    parameter int REG_AW = 12,
    parameter int NREGS  = BANK_REGS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rd_data,
    output logic              rd_hit
);

    logic [31:0]      store_q [NREGS];
    logic [NREGS-1:0] sel;

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        localparam logic [31:0] KEEP = bank_keep(i);

        // Word select for register i.
        assign sel[i] = (addr == REG_AW'(OFF_BANK) + REG_AW'(4 * i));

        // Register i stores only its implemented bits.
        always_ff @(posedge clk) begin
            if (!rst_n)              store_q[i] <= '0;
            else if (wr_en && sel[i]) store_q[i] <= wdata & KEEP;
        end
    end

    // Read mux applying the read-zero masks.
    always_comb begin
        rd_data = '0;
        rd_hit  = 1'b0;
        for (int j = 0; j < NREGS; j++) begin
            if (sel[j]) begin
                rd_data = store_q[j] & ~bank_zero(j);
                rd_hit  = 1'b1;
            end
        end
    end

    AST_BANK_ONESEL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel)); // R8

endmodule

// File: rtl/bwd_window.sv
// Outbound window classifier: maps a CPU address to an 8 MiB chunk of the top
// region and gates it by mode field and enable bitmap. Edge chunks never forward.
// Assumes the region is the top sixteenth of the address space.
module bwd_window
    import bwd_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CHUNK_SHIFT = 23,
    localparam int IDX_W      = ADDR_W - 4 - CHUNK_SHIFT,
    localparam int NCH        = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [1:0]        mode,
    input  logic [NCH-1:0]    enable,
    output logic              hit,
    output logic [IDX_W-1:0]  chunk
);

    logic [NCH-1:0]   chunk_ok;
    logic             in_region;
    logic             mode_on;
    logic [IDX_W-1:0] idx;

    for (genvar c = 0; c < NCH; c++) begin : g_chunk
        if (c == 0 || c == NCH - 1) begin : g_edge
            assign chunk_ok[c] = 1'b0;
        end else begin : g_mid
            assign chunk_ok[c] = enable[c];
        end
    end

    // Region, mode and chunk-index decode.
    always_comb begin
        in_region = (cpu_addr[ADDR_W-1 -: 4] == 4'hF);
        mode_on   = (fwd_mode_e'(mode) == MODE_FWD);
        idx       = cpu_addr[CHUNK_SHIFT +: IDX_W];
    end

    // Final forward decision and chunk report.
    always_comb begin
        hit   = in_region && mode_on && chunk_ok[idx];
        chunk = hit ? idx : '0;
    end

    AST_ENABLED_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> enable[chunk]); // R3
    AST_EDGE_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (chunk != '0 && chunk != '1)); // R4

endmodule

// File: rtl/bwd_io_check.sv
// Legality check for I/O data window accesses by byte offset and byte size.
// Assumes size is coded in bytes; only 1, 2 and 4 are real sizes.
module bwd_io_check (
    input  logic [1:0] offs,
    input  logic [2:0] size,
    output logic       ok
);

    // Offset/size legality table.
    always_comb begin
        case (offs)
            2'd0:    ok = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
            2'd2:    ok = (size == 3'd1) || (size == 3'd2);
            default: ok = (size == 3'd1);
        endcase
    end

endmodule

// File: rtl/bridge_window_decoder.sv
// Top of the bridge outbound window decoder: register file, setup bank,
// window classifier and I/O access check. Reads are combinational.
// Assumes a synchronous active-low reset and single-cycle write strobes.
module bridge_window_decoder
    import bwd_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CHUNK_SHIFT = 23,
    parameter int REG_AW      = 12,
    localparam int IDX_W      = ADDR_W - 4 - CHUNK_SHIFT,
    localparam int NCH        = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              fwd_hit,
    output logic [IDX_W-1:0]  fwd_chunk,
    output logic [31:0]       cfg_bus_addr,
    input  logic [1:0]        io_offs,
    input  logic [2:0]        io_size,
    output logic              io_ok
);

    logic [31:0] ctrl_q, enable_q, cfg_q, bank_rd;
    logic [1:0]  fbb_q;
    logic        bank_hit;

    bwd_ctrl_regs #(.DATA_W(32), .REG_AW(REG_AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
        .wdata(reg_wdata), .ctrl_q(ctrl_q), .enable_q(enable_q),
        .fbb_q(fbb_q), .cfg_q(cfg_q)
    );

    bwd_cfg_bank #(.REG_AW(REG_AW), .NREGS(BANK_REGS)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rd_data(bank_rd), .rd_hit(bank_hit)
    );

    bwd_window #(.ADDR_W(ADDR_W), .CHUNK_SHIFT(CHUNK_SHIFT)) u_win (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr),
        .mode(ctrl_q[MODE_LSB +: 2]), .enable(enable_q[NCH-1:0]),
        .hit(fwd_hit), .chunk(fwd_chunk)
    );

    bwd_io_check u_io (.offs(io_offs), .size(io_size), .ok(io_ok));

    // Word-aligned configuration address toward the downstream bus.
    assign cfg_bus_addr = {cfg_q[31:2], 2'b00};

    // Register read mux.
    always_comb begin
        case (reg_addr)
            REG_AW'(OFF_CTRL):    reg_rdata = ctrl_q;
            REG_AW'(OFF_ENABLE):  reg_rdata = enable_q;
            REG_AW'(OFF_FBB):     reg_rdata = {30'd0, fbb_q};
            REG_AW'(OFF_CFGADDR): reg_rdata = cfg_q;
            default:              reg_rdata = bank_hit ? bank_rd : '0;
        endcase
    end

    AST_OUTSIDE_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[ADDR_W-1 -: 4] != 4'hF) |-> !fwd_hit); // R5
    AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_hit |-> (ctrl_q[MODE_LSB +: 2] == 2'b01)); // R2
    AST_CHUNK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_hit |-> (fwd_chunk == '0)); // R12
    AST_IO_ODD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (io_ok && io_offs[0]) |-> (io_size == 3'd1)); // R11

endmodule

// File: tb/bridge_window_decoder_test.sv
module bridge_window_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] cpu_addr = '0;
    logic        fwd_hit;
    logic [4:0]  fwd_chunk;
    logic [31:0] cfg_bus_addr;
    logic [1:0]  io_offs = '0;
    logic [2:0]  io_size = '0;
    logic        io_ok;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bridge_window_decoder uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr),
        .fwd_hit(fwd_hit), .fwd_chunk(fwd_chunk), .cfg_bus_addr(cfg_bus_addr),
        .io_offs(io_offs), .io_size(io_size), .io_ok(io_ok)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    // Expected decode for one address.
    task automatic decode_check(input logic [31:0] a, input int mode, input logic [31:0] en);
        int  c;
        bit  exp_hit;
        string tag;
        c = int'(a[27:23]);
        exp_hit = (a[31:28] == 4'hF) && (mode == 1) && (c >= 1) && (c <= 30) && en[c];
        if (a[31:28] != 4'hF)        tag = "R5";
        else if (c == 0 || c == 31)  tag = "R4";
        else if (mode != 1)          tag = "R2";
        else                         tag = "R3";
        cpu_addr = a;
        #1;
        check(tag, {31'd0, fwd_hit}, {31'd0, exp_hit});
        check("R12", {27'd0, fwd_chunk}, exp_hit ? 32'(c) : 32'd0);
    endtask

    task automatic sweep(input int mode, input logic [31:0] en);
        wr(12'h000, 32'(mode) << 7);
        wr(12'h004, en);
        for (int c = 0; c < 32; c++) begin
            decode_check(32'hF000_0000 + (32'(c) << 23), mode, en);
            decode_check(32'hF000_0000 + (32'(c) << 23) + 32'h007F_FFFF, mode, en);
            decode_check(32'hF000_0000 + (32'(c) << 23) + 32'h0012_3450, mode, en);
        end
    endtask

    initial begin
        int widths [13] = '{1, 7, 7, 8, 7, 9, 32, 8, 30, 24, 22, 32, 9};
        logic [31:0] zmask, keep, pat, exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        rd_check("R1", 12'h000, 0);
        rd_check("R1", 12'h004, 0);
        rd_check("R1", 12'h008, 0);
        rd_check("R1", 12'h00C, 0);
        for (int i = 0; i < 13; i++) rd_check("R1", 12'h800 + 12'(4 * i), 0);
        check("R1", cfg_bus_addr, 0);
        cpu_addr = 32'hF080_0000; #1;
        check("R1", {31'd0, fwd_hit}, 0);

        // R7 fast-back-to-back width
        wr(12'h008, 32'hFFFF_FFFF); rd_check("R7", 12'h008, 32'h3);
        wr(12'h008, 32'h0000_0006); rd_check("R7", 12'h008, 32'h2);

        // R10 configuration address
        wr(12'h00C, 32'h1234_5677);
        rd_check("R10", 12'h00C, 32'h1234_5677);
        check("R10", cfg_bus_addr, 32'h1234_5674);
        wr(12'h00C, 32'h8000_0002);
        rd_check("R10", 12'h00C, 32'h8000_0002);
        check("R10", cfg_bus_addr, 32'h8000_0000);

        // R8 / R9 bank masks under two patterns
        for (int p = 0; p < 2; p++) begin
            pat = (p == 0) ? 32'hFFFF_FFFF : 32'hA5C3_5A3C;
            for (int i = 0; i < 13; i++) wr(12'h800 + 12'(4 * i), pat);
            for (int i = 0; i < 13; i++) begin
                keep = (widths[i] >= 32) ? 32'hFFFF_FFFF : ((32'd1 << widths[i]) - 1);
                zmask = 0;
                if (i == 1) zmask = 32'h1;
                if (i == 7) zmask = 32'h7;
                if (i == 8) zmask = (32'd1 << 3) | (32'd7 << 5) | (32'd1 << 15) | (32'd1 << 24);
                exp = pat & keep & ~zmask;
                rd_check((zmask != 0) ? "R9" : "R8", 12'h800 + 12'(4 * i), exp);
            end
        end
        rd_check("R12", 12'h834, 0);
        rd_check("R12", 12'h010, 0);

        // R11 I/O access legality, all pairs
        for (int o = 0; o < 4; o++) begin
            for (int s = 0; s < 8; s++) begin
                bit ok;
                ok = (s == 1) || (o == 0 && (s == 2 || s == 4)) || (o == 2 && s == 2);
                io_offs = 2'(o); io_size = 3'(s); #1;
                check("R11", {31'd0, io_ok}, {31'd0, ok});
            end
        end

        // R2 / R3 / R4 / R12 sweeps
        for (int m = 0; m < 4; m++) begin
            sweep(m, 32'hFFFF_FFFF);
            sweep(m, 32'hAAAA_AAAA);
            sweep(m, 32'h5555_5555);
        end
        for (int k = 0; k < 32; k++) sweep(1, 32'd1 << k);
        wr(12'h004, 32'h8000_0001);
        rd_check("R4", 12'h004, 32'h8000_0001);
        decode_check(32'hF000_0000, 1, 32'h8000_0001);
        decode_check(32'hFF80_0004, 1, 32'h8000_0001);

        // R5 outside the region
        wr(12'h004, 32'hFFFF_FFFF);
        decode_check(32'h0000_0000, 1, 32'hFFFF_FFFF);
        decode_check(32'hEFFF_FFFF, 1, 32'hFFFF_FFFF);
        decode_check(32'h7080_0000, 1, 32'hFFFF_FFFF);
        decode_check(32'h8800_0000, 1, 32'hFFFF_FFFF);

        // R6 write and decode in the same cycle
        cpu_addr = 32'hF280_0000;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 12'h004; reg_wdata = 32'h0;
        #1 check("R6", {31'd0, fwd_hit}, 1);
        @(posedge clk); #1 check("R6", {31'd0, fwd_hit}, 0);
        @(negedge clk);
        reg_wdata = 32'h0000_0020;
        #1 check("R6", {31'd0, fwd_hit}, 0);
        @(posedge clk); #1 check("R6", {31'd0, fwd_hit}, 1);
        @(negedge clk);
        reg_addr = 12'h000; reg_wdata = 32'h0000_0100;
        #1 check("R6", {31'd0, fwd_hit}, 1);
        @(posedge clk); #1 check("R6", {31'd0, fwd_hit}, 0);
        @(negedge clk);
        reg_wdata = 32'h0000_0080;
        #1 check("R6", {31'd0, fwd_hit}, 0);
        @(posedge clk); #1 check("R6", {31'd0, fwd_hit}, 1);
        check("R6", {27'd0, fwd_chunk}, 32'd5);
        @(negedge clk);
        reg_wr = 1'b0;

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule